// File: doc/BRIEF.md
# Counter-Pattern Test Event Generator with Link Framing

This block produces a synthetic test event each time it sees a trigger, so a downstream readout board can be exercised without live detector data. An event is framed for a 16-bit link: a fixed start word, a run of identical payload words, an all-zero flag word, a word that carries a checksum, and a fixed end word. Every 32-bit word goes out as two 16-bit transfers, upper half first, one transfer per clock.

Each payload word joins a fixed 4-bit channel tag, set by a parameter (0x1 for the first channel, 0x2 for the second), with a 28-bit event number. The event number advances once for each event sent, so the receiver can spot lost events. A CRC-16 is computed inline over the body and placed in the slot just before the end word. A busy input lets a downstream stage hold off new events. Triggers that arrive while an event is being sent are thrown away.

Top module: `evtInjector`

## Requirements
- R1: After reset, and between events, txValid, txStart and txEnd are low and txData is 0x0000.
- R2: When a rising edge on trigIn is sampled in idle with busyIn low, the first transfer appears on the next cycle. The start word is sent as 0x5111 then 0x5110, and txStart is high only on the 0x5111 transfer.
- R3: After the start word come wordCount payload words. Each is sent as {CHAN_ID[3:0], evtNum[27:16]} then evtNum[15:0].
- R4: evtNum is 0 for the first event after reset and grows by one for each event fully sent. Dropped triggers do not advance it.
- R5: After the payload come the flag transfers 0x0000, 0x0000, then the checksum word (0x0000, then the CRC), then the end word 0x3FFF, 0x3FF0. txEnd is high only on the 0x3FF0 transfer.
- R6: The CRC uses polynomial 0x1021 with seed 0xFFFF, MSB first, with no reflection and no final XOR. It runs over the 16-bit transfers from the first payload transfer through the second flag transfer.
- R7: wordCount is captured when an event starts. A value of 0 puts the flag word straight after the start word.
- R8: txValid stays high without a gap from the first start-word transfer through the last end-word transfer.
- R9: A trigger edge sampled while an event is in progress is discarded, even in the event's final cycle. No further event follows.
- R10: While busyIn is high in idle, no event starts. A trigger edge seen during that time is kept, and its event starts on the cycle after busyIn is sampled low.
- R11: A trigger held high for many cycles produces exactly one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigIn | input | 1 | Trigger; a rising edge requests an event |
| busyIn | input | 1 | Downstream busy; holds off the start of an event |
| wordCount | input | LEN_W | Number of 32-bit payload words per event |
| txData | output | 16 | Link transfer data |
| txValid | output | 1 | High while a transfer is on txData |
| txStart | output | 1 | Marks the first transfer of an event |
| txEnd | output | 1 | Marks the last transfer of an event |

## Verification
Two things can land in the same cycle: a new trigger edge and the final end-word transfer of the event in progress. The bench raises trigIn so that its edge is sampled exactly on the txEnd cycle. It then checks that the link stays idle and that the next event carries an event number only one higher. The bench also sends a trigger on the first idle cycle after an event and expects an immediate, back-to-back event. Randomized lengths and gaps, together with the directed zero-length and busy cases, are checked against frames built by bench functions.

// File: rtl/injPkg.sv
package injPkg;
  typedef enum logic [2:0] {F_IDLE, F_HDR, F_PAY, F_FLAG, F_CRC, F_TRL} fld_e;

  typedef struct packed {
    logic active;
    fld_e field;
    logic half;
    logic crcInit;
    logic crcEn;
    logic evtDone;
  } strobe_t;

  localparam logic [31:0] HDR_WORD = 32'h5111_5110;
  localparam logic [31:0] TRL_WORD = 32'h3FFF_3FF0;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;
  localparam int          CNT_W    = 28;

  function automatic logic [15:0] crcStep(input logic [15:0] crcIn, input logic [15:0] dIn);
    logic [15:0] c;
    logic fb;
    c = crcIn;
    for (int i = 15; i >= 0; i--) begin
      fb = c[15] ^ dIn[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/injCtrl.sv
module injCtrl
  import injPkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigIn,
  input  logic             busyIn,
  input  logic [LEN_W-1:0] wordCount,
  output strobe_t          stb
);
  localparam logic [LEN_W-1:0] LEN_ONE = 1;

  fld_e             st;
  logic             half;
  logic             trigQ;
  logic             pending;
  logic [LEN_W-1:0] lenQ;
  logic [LEN_W-1:0] idx;
  logic             trigRise;

  assign trigRise = trigIn & ~trigQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= F_IDLE;
      half    <= 1'b0;
      trigQ   <= 1'b0;
      pending <= 1'b0;
      lenQ    <= '0;
      idx     <= '0;
    end else begin
      trigQ <= trigIn;
      if (st == F_IDLE) begin
        if ((trigRise || pending) && !busyIn) begin
          st      <= F_HDR;
          half    <= 1'b0;
          lenQ    <= wordCount;
          pending <= 1'b0;
        end else if (trigRise) begin
          pending <= 1'b1;
        end
      end else begin
        // edges seen mid-event are discarded
        pending <= 1'b0;
        half    <= ~half;
        if (half) begin
          case (st)
            F_HDR: begin
              idx <= '0;
              st  <= (lenQ == '0) ? F_FLAG : F_PAY;
            end
            F_PAY: begin
              if (idx == lenQ - LEN_ONE) st <= F_FLAG;
              else idx <= idx + LEN_ONE;
            end
            F_FLAG:  st <= F_CRC;
            F_CRC:   st <= F_TRL;
            default: st <= F_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    stb.active  = (st != F_IDLE);
    stb.field   = st;
    stb.half    = half;
    stb.crcInit = (st == F_HDR);
    stb.crcEn   = (st == F_PAY) || (st == F_FLAG);
    stb.evtDone = (st == F_TRL) && half;
  end
endmodule

// File: rtl/injDatapath.sv
module injDatapath
  import injPkg::*;
#(
  parameter logic [3:0] CHAN_ID = 4'h1
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  output logic [15:0]   txData,
  output logic          txValid,
  output logic          txStart,
  output logic          txEnd
);
  logic [CNT_W-1:0] evtNum;
  logic [15:0]      crcQ;
  logic [31:0]      word32;
  logic [15:0]      dOut;

  always_comb begin
    case (stb.field)
      F_HDR:   word32 = HDR_WORD;
      F_PAY:   word32 = {CHAN_ID, evtNum};
      F_CRC:   word32 = {16'h0000, crcQ};
      F_TRL:   word32 = TRL_WORD;
      default: word32 = '0;
    endcase
    dOut = stb.active ? (stb.half ? word32[15:0] : word32[31:16]) : 16'h0000;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtNum <= '0;
      crcQ   <= CRC_SEED;
    end else begin
      if (stb.evtDone) evtNum <= evtNum + 1'b1;
      if (stb.crcInit)    crcQ <= CRC_SEED;
      else if (stb.crcEn) crcQ <= crcStep(crcQ, dOut);
    end
  end

  assign txData  = dOut;
  assign txValid = stb.active;
  assign txStart = (stb.field == F_HDR) && !stb.half;
  assign txEnd   = stb.evtDone;
endmodule

// File: rtl/evtInjector.sv
module evtInjector
  import injPkg::*;
#(
  parameter logic [3:0] CHAN_ID = 4'h1,
  parameter int         LEN_W   = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigIn,
  input  logic             busyIn,
  input  logic [LEN_W-1:0] wordCount,
  output logic [15:0]      txData,
  output logic             txValid,
  output logic             txStart,
  output logic             txEnd
);
  strobe_t stb;

  injCtrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .busyIn(busyIn),
    .wordCount(wordCount), .stb(stb)
  );

  injDatapath #(.CHAN_ID(CHAN_ID)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .txData(txData),
    .txValid(txValid), .txStart(txStart), .txEnd(txEnd)
  );
endmodule

// File: rtl/injChecker.sv
module injChecker (
  input logic        clk,
  input logic        rstN,
  input logic        busyIn,
  input logic [15:0] txData,
  input logic        txValid,
  input logic        txStart,
  input logic        txEnd
);
  AST_START_WORD: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> (txValid && txData == 16'h5111 && $rose(txValid))); // R2
  AST_START_LOW_HALF: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> (txValid && txData == 16'h5110)); // R2
  AST_END_WORD: assert property (@(posedge clk) disable iff (!rstN)
    txEnd |-> (txData == 16'h3FF0 && $past(txData) == 16'h3FFF)); // R5
  AST_MARK_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({txStart, txEnd})); // R5
  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txEnd) |=> txValid); // R8
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    txEnd |=> !txValid); // R9
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txValid) |-> !$past(busyIn)); // R10
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !txValid |-> (txData == 16'h0000)); // R1
endmodule

bind evtInjector injChecker chk_i (
  .clk(clk), .rstN(rstN), .busyIn(busyIn), .txData(txData),
  .txValid(txValid), .txStart(txStart), .txEnd(txEnd)
);

// File: tb/evtInjector_tb_top.sv
module evtInjector_tb_top;
  localparam int         LEN_W   = 10;
  localparam logic [3:0] CHAN_ID = 4'h1;
  localparam int         MAXT    = 2 * 1023 + 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigIn = 1'b0;
  logic busyIn = 1'b0;
  logic [LEN_W-1:0] wordCount = '0;
  logic [15:0] txData;
  logic txValid, txStart, txEnd;

  int checks = 0;
  int errors = 0;
  logic [27:0] expNum = '0;
  logic [15:0] got [MAXT];
  int gotN;

  always #10 clk = ~clk;

  evtInjector #(.CHAN_ID(CHAN_ID), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .busyIn(busyIn),
    .wordCount(wordCount), .txData(txData), .txValid(txValid),
    .txStart(txStart), .txEnd(txEnd)
  );

  function automatic logic [15:0] benchCrc(input logic [15:0] c0, input logic [15:0] d);
    logic [15:0] c = c0;
    for (int b = 15; b >= 0; b--) begin
      if (c[15] ^ d[b]) c = {c[14:0], 1'b0} ^ 16'h1021;
      else              c = {c[14:0], 1'b0};
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic idleCheck(input string req);
    check(!txValid && !txStart && !txEnd && txData == 16'h0000, req,
          {12'h0, txValid, txStart, txEnd, 1'b0, txData}, 32'h0);
  endtask

  // called at a negedge where the first transfer is visible
  task automatic collect(input int injectAt);
    int guard = 0;
    gotN = 0;
    forever begin
      got[gotN] = txData;
      if (injectAt >= 0) trigIn = (gotN == injectAt);
      gotN++;
      if (txEnd || gotN >= MAXT || guard > 4000) break;
      guard++;
      @(negedge clk);
    end
    if (injectAt >= 0) begin
      @(negedge clk);
      trigIn = 1'b0;
    end
  endtask

  task automatic judge(input int n);
    int bad = 0;
    logic [15:0] c = 16'hFFFF;
    logic [15:0] hi = {CHAN_ID, expNum[27:16]};
    logic [15:0] lo = expNum[15:0];
    check(gotN == 2 * n + 8, "R7 length", gotN, 2 * n + 8);
    if (gotN == 2 * n + 8) begin
      check(got[0] == 16'h5111 && got[1] == 16'h5110, "R2 start word", {got[0], got[1]}, 32'h51115110);
      for (int i = 0; i < n; i++) begin
        if (got[2 + 2 * i] != hi || got[3 + 2 * i] != lo) bad++;
        c = benchCrc(benchCrc(c, hi), lo);
      end
      check(bad == 0, "R3 R4 payload", n > 0 ? {got[2], got[3]} : 32'h0, n > 0 ? {hi, lo} : 32'h0);
      c = benchCrc(benchCrc(c, 16'h0000), 16'h0000);
      check(got[2 * n + 2] == 0 && got[2 * n + 3] == 0 && got[2 * n + 4] == 0 && got[2 * n + 5] == c,
            "R6 flag and crc", {got[2 * n + 4], got[2 * n + 5]}, {16'h0, c});
      check(got[2 * n + 6] == 16'h3FFF && got[2 * n + 7] == 16'h3FF0, "R5 end word",
            {got[2 * n + 6], got[2 * n + 7]}, 32'h3FFF3FF0);
    end
    expNum = expNum + 1'b1;
  endtask

  // pulse (or hold) trigger, check latency of first transfer
  task automatic launch(input int n, input bit hold);
    wordCount = LEN_W'(n);
    @(negedge clk);
    trigIn = 1'b1;
    @(negedge clk);
    if (!hold) trigIn = 1'b0;
    check(txValid && txStart && txData == 16'h5111, "R2 latency", {txValid, txStart, txData}, 32'h35111);
  endtask

  initial begin
    int seed = $urandom(32'h5EED1234);
    int n;
    repeat (3) @(negedge clk);
    idleCheck("R1 reset");
    rstN = 1'b1;
    @(negedge clk);
    idleCheck("R1 after reset");

    // directed: typical length, first event number 0
    launch(176, 1'b0); collect(-1); judge(176);
    @(negedge clk); idleCheck("R1 between events");

    // zero and one payload words
    launch(0, 1'b0); collect(-1); judge(0);
    launch(1, 1'b0); collect(-1); judge(1);

    // wordCount change during event has no effect (captured at start)
    launch(5, 1'b0); wordCount = 10'd40; collect(-1); judge(5);

    // trigger mid-event dropped
    launch(6, 1'b0); collect(4); judge(6);
    repeat (3) @(negedge clk);
    idleCheck("R9 mid-event trigger");

    // trigger edge sampled on final transfer cycle dropped
    launch(3, 1'b0); collect(2 * 3 + 7); judge(3);
    repeat (3) @(negedge clk);
    idleCheck("R9 final-cycle trigger");
    launch(2, 1'b0); collect(-1); judge(2);

    // back-to-back: trigger on first idle cycle
    launch(2, 1'b0); collect(-1);
    judge(2);
    launch(4, 1'b0); collect(-1); judge(4);

    // held trigger yields a single event
    launch(3, 1'b1); collect(-1); judge(3);
    repeat (6) @(negedge clk);
    idleCheck("R11 held trigger");
    trigIn = 1'b0;

    // busy holds start, pending edge released later
    busyIn = 1'b1; wordCount = 10'd2;
    @(negedge clk); trigIn = 1'b1;
    @(negedge clk); trigIn = 1'b0;
    repeat (8) @(negedge clk);
    idleCheck("R10 busy hold");
    busyIn = 1'b0;
    @(negedge clk);
    check(txValid && txStart, "R10 release", {txValid, txStart}, 2'b11);
    collect(-1); judge(2);
    repeat (4) @(negedge clk);
    idleCheck("R10 single event");

    // random lengths and gaps
    for (int k = 0; k < 30; k++) begin
      n = $urandom_range(0, 40);
      repeat ($urandom_range(0, 5)) @(negedge clk);
      launch(n, 1'b0); collect(-1); judge(n);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule